// File: doc/BRIEF.md
# Triple Interval/Match Timer

This block holds three independent 16-bit timer channels behind one 32-bit register port. Each channel has an optional prescaler and counts up or down. In free-running mode it wraps through the full 16-bit range. In interval mode it wraps at a programmed limit. Three comparators per channel report when the count reaches their values. Every channel keeps a six-bit interrupt status that clears when it is read, and drives one interrupt line from the status bits that software has enabled.

Software reaches the registers through a word-aligned byte offset. The offset is split into a word number. The word number modulo three picks the channel, and the word number divided by three picks the register group. The channels therefore sit interleaved, one word apart, inside each group. `tick_en` is the timer clock enable and is shared by all channels. A channel's counting logic does nothing in cycles where `tick_en` is low.

Top module: `tmr_trio`

## Requirements
- R1: After reset, every channel's control register reads 0x21, so the channel is disabled. All other registers read 0, and `irq` is all zeros.
- R2: Register widths are as follows: clock setup 6 bits, interval and the three match values 16 bits, interrupt enable 6 bits, event control 3 bits. The count reads as a 16-bit value with zeros above and cannot be written. The event word (group 10) and every offset beyond group 10 read as 0.
- R3: The byte offset is addressed as follows. word = offset>>2, channel = word mod 3, group = word div 3. The groups are: 0 clock setup, 1 control, 2 count, 3 interval, 4 match 1, 5 match 2, 6 match 3, 7 status, 8 interrupt enable, 9 event control, 10 event.
- R4: The control bits are: bit 0 stops counting, bit 1 selects interval mode, bit 2 selects down-counting, bit 3 enables the comparators, and bit 4 restarts the count. Writing bit 4 as 1 sets the count and the prescaler phase to 0. Bit 4 always reads back as 0.
- R5: Clock setup bit 0 enables the prescaler, and bits 4:1 hold N. With the prescaler enabled, the count moves once per 2^(N+1) cycles with `tick_en` high. With it disabled, the count moves on every such cycle, whatever N holds.
- R6: When counting up, the count runs from 0 to the top value and then returns to 0. The top value is the interval value in interval mode and 0xFFFF otherwise. That return sets status bit 0 in interval mode and status bit 4 otherwise.
- R7: When counting down, a step from 0 loads the top value. This sets the same status bit as R6.
- R8: When bit 3 of control is 1 and a step lands the count on match value k (k = 1..3), status bit k is set. A match value above the top value never sets its bit. With bit 3 at 0, no match bit is set.
- R9: A read of the status register returns its contents and clears them. A write to it has no effect. An event that arrives in the same cycle as the read is kept and appears on the next read.
- R10: `irq[c]` is high exactly when channel c's status AND its interrupt enable is nonzero.
- R11: The channels count and flag independently. A stopped channel keeps its count while the others run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable shared by the channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on a status read) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 3 | One interrupt line per channel |

## Verification
A count or prescaler phase that has drifted shows up at the count register in the first read after a known number of enabled cycles. The sweeps check every count value over several wraps, so an off-by-one limit or reload appears within one period. A wrong status bit, a lost event or a stale clear shows up on the next status read, or on `irq` in the same cycle once the enable is set. A decode fault in the interleaved map shows up as a value read back from the wrong channel or group.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Register groups; the order is the address order (word div channels).
    typedef enum logic [3:0] {
        G_CLK = 4'd0,
        G_CTL = 4'd1,
        G_CNT = 4'd2,
        G_IVL = 4'd3,
        G_M1  = 4'd4,
        G_M2  = 4'd5,
        G_M3  = 4'd6,
        G_STS = 4'd7,
        G_IEN = 4'd8,
        G_EVC = 4'd9,
        G_EVT = 4'd10
    } grp_e;

    localparam int NUM_GRP = 11;
    localparam int NM      = 3;     // comparators per channel

    // control bit positions
    localparam int CB_OFF  = 0;
    localparam int CB_IVL  = 1;
    localparam int CB_DOWN = 2;
    localparam int CB_MEN  = 3;
    localparam int CB_RST  = 4;

    // status bit positions (match k sits at bit k)
    localparam int SB_IVL  = 0;
    localparam int SB_OVF  = 4;

    localparam logic [5:0] CTL_INIT = 6'h21;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run,
    input  logic          clr,
    input  logic          ps_en,
    input  logic [NW-1:0] ps_n,
    output logic          step
);
    localparam int PW = 2 ** NW;

    typedef struct packed {
        logic [PW-1:0] ph;
    } ps_s;

    ps_s q, d;
    logic [PW:0]   span;
    logic [PW-1:0] lim;
    logic          at_lim;

    always_comb begin
        span   = ({{PW{1'b0}}, 1'b1} << ps_n) << 1;
        lim    = PW'(span - 1'b1);
        at_lim = (q.ph == lim);
        step   = run && tick_en && (!ps_en || at_lim);
        d      = q;
        if (clr) begin
            d.ph = '0;
        end else if (run && tick_en && ps_en) begin
            d.ph = at_lim ? '0 : q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic        rd_clr,
    input  grp_e        grp,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    typedef struct packed {
        logic [5:0]               clk_cfg;
        logic [5:0]               ctl;
        logic [CW-1:0]            cnt;
        logic [CW-1:0]            ivl;
        logic [NM-1:0][CW-1:0]    mat;
        logic [5:0]               sts;
        logic [5:0]               ien;
        logic [2:0]               evc;
    } ch_s;

    ch_s q, d;

    logic          step;
    logic          restart;
    logic [CW-1:0] top;
    logic [CW-1:0] nxt;
    logic          wrap;
    logic [NM-1:0] hit;
    logic [5:0]    set_bits;

    assign restart = wr_en && (grp == G_CTL) && wdata[CB_RST];

    tmr_presc #(.NW(4)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (!q.ctl[CB_OFF]),
        .clr     (restart),
        .ps_en   (q.clk_cfg[0]),
        .ps_n    (q.clk_cfg[4:1]),
        .step    (step)
    );

    always_comb begin
        top  = q.ctl[CB_IVL] ? q.ivl : '1;
        nxt  = q.cnt;
        wrap = 1'b0;
        if (step) begin
            if (q.ctl[CB_DOWN]) begin
                if (q.cnt == '0) begin
                    nxt  = top;
                    wrap = 1'b1;
                end else begin
                    nxt = q.cnt - 1'b1;
                end
            end else begin
                if (q.cnt >= top) begin
                    nxt  = '0;
                    wrap = 1'b1;
                end else begin
                    nxt = q.cnt + 1'b1;
                end
            end
        end
        for (int k = 0; k < NM; k++) begin
            hit[k] = step && q.ctl[CB_MEN] && (q.mat[k] <= top) && (nxt == q.mat[k]);
        end
        set_bits         = '0;
        set_bits[SB_IVL] = wrap && q.ctl[CB_IVL];
        set_bits[SB_OVF] = wrap && !q.ctl[CB_IVL];
        set_bits[NM:1]   = hit;

        d     = q;
        d.cnt = nxt;
        d.sts = (rd_clr ? 6'h00 : q.sts) | set_bits;
        if (wr_en) begin
            case (grp)
                G_CLK: d.clk_cfg = wdata[5:0];
                G_CTL: begin
                    d.ctl         = wdata[5:0];
                    d.ctl[CB_RST] = 1'b0;
                    if (wdata[CB_RST]) d.cnt = '0;
                end
                G_IVL: d.ivl    = wdata[CW-1:0];
                G_M1:  d.mat[0] = wdata[CW-1:0];
                G_M2:  d.mat[1] = wdata[CW-1:0];
                G_M3:  d.mat[2] = wdata[CW-1:0];
                G_IEN: d.ien    = wdata[5:0];
                G_EVC: d.evc    = wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (grp)
            G_CLK: rdata[5:0]    = q.clk_cfg;
            G_CTL: rdata[5:0]    = q.ctl;
            G_CNT: rdata[CW-1:0] = q.cnt;
            G_IVL: rdata[CW-1:0] = q.ivl;
            G_M1:  rdata[CW-1:0] = q.mat[0];
            G_M2:  rdata[CW-1:0] = q.mat[1];
            G_M3:  rdata[CW-1:0] = q.mat[2];
            G_STS: rdata[5:0]    = q.sts;
            G_IEN: rdata[5:0]    = q.ien;
            G_EVC: rdata[2:0]    = q.evc;
            default: rdata = '0;
        endcase
    end

    assign irq = |(q.sts & q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.ctl <= CTL_INIT;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/tmr_trio.sv
module tmr_trio
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int AW     = 8,
    parameter int CW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq
);
    int   word_i, grp_i, ch_i;
    logic in_map;
    grp_e grp;
    logic [31:0] ch_rd [NUM_CH];

    always_comb begin
        word_i = int'(addr[AW-1:2]);
        grp_i  = word_i / NUM_CH;
        ch_i   = word_i % NUM_CH;
        in_map = (grp_i < NUM_GRP);
        grp    = grp_e'(grp_i[3:0]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = in_map && (ch_i == c);
        tmr_chan #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wr_en   (wr_en && sel),
            .rd_clr  (rd_en && sel && (grp == G_STS)),
            .grp     (grp),
            .wdata   (wdata),
            .rdata   (ch_rd[c]),
            .irq     (irq[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_map && (ch_i == c)) rdata = ch_rd[c];
        end
    end
endmodule

module tmr_trio_chk #(
    parameter int NUM_CH = 3,
    parameter int AW     = 8,
    parameter int CW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              rd_en,
    input logic [AW-1:0]     addr,
    input logic [31:0]       rdata,
    input logic [NUM_CH-1:0] irq
);
    int grp_c;
    always_comb grp_c = int'(addr[AW-1:2]) / NUM_CH;

    // R1: no interrupt straight out of reset
    assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0));

    // R2: event word and unmapped space read zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_c >= 10) |-> (rdata == 32'h0));

    // R2: count readback is CW bits wide
    assert_count_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_c == 2) |-> (rdata[31:CW] == '0));

    // R2: clock setup readback is 6 bits wide
    assert_clk_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_c == 0) |-> (rdata[31:6] == '0));

    // R4: restart bit never reads back as 1
    assert_ctl_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_c == 1) |-> (rdata[4] == 1'b0 && rdata[31:6] == '0));

    // R9: a status read with no step pending leaves the status empty
    assert_sts_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && grp_c == 7 && !tick_en) |=>
        ((rd_en && $stable(addr)) -> (rdata == 32'h0)));
endmodule

bind tmr_trio tmr_trio_chk #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_tmr_trio.sv
module sim_tmr_trio;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;

    localparam int G_CLK = 0, G_CTL = 1, G_CNT = 2, G_IVL = 3, G_M1 = 4, G_M2 = 5,
                   G_M3 = 6, G_STS = 7, G_IEN = 8, G_EVC = 9, G_EVT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_trio u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] ra(input int g, input int c);
        return 8'((g * NCH + c) * 4);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int g, input int c, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ra(g, c); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rda(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #(CLK_P/4);
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd(input int g, input int c, output logic [31:0] d);
        rda(ra(g, c), d);
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic setup(input int c, input logic [31:0] ck, input logic [31:0] iv,
                         input logic [31:0] ctl);
        logic [31:0] junk;
        wr(G_CLK, c, ck);
        wr(G_IVL, c, iv);
        wr(G_CTL, c, ctl | 32'h10);
        rd(G_STS, c, junk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        chk("R1", "irq after reset", 32'(irq), 32'h0);

        // R1: reset values on every channel
        for (int c = 0; c < NCH; c++) begin
            rd(G_CTL, c, v); chk("R1", "control reset", v, 32'h21);
            rd(G_CLK, c, v); chk("R1", "clock reset", v, 32'h0);
            rd(G_CNT, c, v); chk("R1", "count reset", v, 32'h0);
            rd(G_STS, c, v); chk("R1", "status reset", v, 32'h0);
            rd(G_IEN, c, v); chk("R1", "enable reset", v, 32'h0);
        end

        // R2: widths, read-only count, zero words
        wr(G_CLK, 0, 32'hFFFF_FFFF); rd(G_CLK, 0, v); chk("R2", "clock width", v, 32'h3F);
        wr(G_IVL, 0, 32'hFFFF_FFFF); rd(G_IVL, 0, v); chk("R2", "interval width", v, 32'hFFFF);
        wr(G_M1, 0, 32'hFFFF_FFFF);  rd(G_M1, 0, v);  chk("R2", "match1 width", v, 32'hFFFF);
        wr(G_M2, 0, 32'hFFFF_FFFF);  rd(G_M2, 0, v);  chk("R2", "match2 width", v, 32'hFFFF);
        wr(G_M3, 0, 32'hFFFF_FFFF);  rd(G_M3, 0, v);  chk("R2", "match3 width", v, 32'hFFFF);
        wr(G_IEN, 0, 32'hFFFF_FFFF); rd(G_IEN, 0, v); chk("R2", "enable width", v, 32'h3F);
        wr(G_EVC, 0, 32'hFFFF_FFFF); rd(G_EVC, 0, v); chk("R2", "event ctrl width", v, 32'h7);
        wr(G_CNT, 0, 32'h1234);      rd(G_CNT, 0, v); chk("R2", "count write ignored", v, 32'h0);
        rd(G_EVT, 0, v); chk("R2", "event word", v, 32'h0);
        for (int a = 132; a < 256; a += 4) begin
            rda(8'(a), v); chk("R2", "unmapped offset", v, 32'h0);
        end
        wr(G_STS, 0, 32'h3F); rd(G_STS, 0, v); chk("R9", "status write ignored", v, 32'h0);
        wr(G_IEN, 0, 0); wr(G_CLK, 0, 0);

        // R3: interleaved map
        for (int c = 0; c < NCH; c++) begin
            wr(G_IVL, c, 32'h100 + c);
            wr(G_M1, c, 32'h200 + c);
            wr(G_M2, c, 32'h300 + c);
        end
        for (int c = 0; c < NCH; c++) begin
            rd(G_IVL, c, v); chk("R3", "interval per channel", v, 32'h100 + c);
            rd(G_M1, c, v);  chk("R3", "match1 per channel", v, 32'h200 + c);
            rd(G_M2, c, v);  chk("R3", "match2 per channel", v, 32'h300 + c);
        end

        // R4: control bits
        wr(G_CTL, 1, 32'h3F); rd(G_CTL, 1, v); chk("R4", "restart bit self-clears", v, 32'h2F);
        wr(G_CLK, 1, 0);
        wr(G_CTL, 1, 32'h11); run(5); rd(G_CNT, 1, v); chk("R4", "stopped count", v, 32'h0);
        wr(G_CTL, 1, 32'h00); run(5); rd(G_CNT, 1, v); chk("R4", "running count", v, 32'h5);
        wr(G_CTL, 1, 32'h10); rd(G_CNT, 1, v); chk("R4", "restart forces zero", v, 32'h0);

        // R5: prescaler sweep
        for (int n = 0; n < 4; n++) begin
            setup(1, 32'(1 | (n << 1)), 0, 0);
            run(37);
            rd(G_CNT, 1, v); chk("R5", "prescaled count", v, 32'(37 >> (n + 1)));
        end
        setup(1, 32'h6, 0, 0); run(37);
        rd(G_CNT, 1, v); chk("R5", "prescaler off ignores N", v, 32'd37);

        // R6 / R7: interval sweeps up and down
        for (int l = 1; l <= 5; l++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int n = 0; n <= 2 * l + 3; n++) begin
                    int exp_c;
                    int exp_s;
                    setup(2, 0, 32'(l), 32'(32'h02 | (dn << 2)));
                    run(n);
                    if (dn == 0) begin
                        exp_c = n % (l + 1);
                        exp_s = (n >= l + 1) ? 1 : 0;
                    end else begin
                        exp_c = ((l + 1) - n % (l + 1)) % (l + 1);
                        exp_s = (n >= 1) ? 1 : 0;
                    end
                    rd(G_CNT, 2, v);
                    chk(dn ? "R7" : "R6", "interval count", v, 32'(exp_c));
                    rd(G_STS, 2, v);
                    chk(dn ? "R7" : "R6", "interval wrap flag", v, 32'(exp_s));
                end
            end
        end

        // R6 / R7: free-running wraps at 0xFFFF
        setup(2, 0, 0, 32'h04); run(1);
        rd(G_CNT, 2, v); chk("R7", "down reload to FFFF", v, 32'hFFFF);
        rd(G_STS, 2, v); chk("R7", "down overflow flag", v, 32'h10);
        wr(G_CTL, 2, 32'h00); run(1);
        rd(G_CNT, 2, v); chk("R6", "up wrap to zero", v, 32'h0);
        rd(G_STS, 2, v); chk("R6", "up overflow flag", v, 32'h10);

        // R8: comparators
        wr(G_M1, 0, 3); wr(G_M2, 0, 7); wr(G_M3, 0, 12);
        for (int n = 0; n <= 12; n++) begin
            int exp_s;
            exp_s = ((n >= 3) ? 2 : 0) | ((n >= 7) ? 4 : 0) | ((n >= 10) ? 1 : 0);
            setup(0, 0, 9, 32'h0A); run(n);
            rd(G_STS, 0, v); chk("R8", "match flags up", v, 32'(exp_s));
        end
        setup(0, 0, 9, 32'h02); run(12);
        rd(G_STS, 0, v); chk("R8", "match disabled", v, 32'h01);
        setup(0, 0, 9, 32'h0E); run(2);
        rd(G_STS, 0, v); chk("R8", "down n=2", v, 32'h01);
        setup(0, 0, 9, 32'h0E); run(3);
        rd(G_STS, 0, v); chk("R8", "down n=3", v, 32'h05);
        setup(0, 0, 9, 32'h0E); run(6);
        rd(G_STS, 0, v); chk("R8", "down n=6", v, 32'h05);
        setup(0, 0, 9, 32'h0E); run(7);
        rd(G_STS, 0, v); chk("R8", "down n=7", v, 32'h07);
        wr(G_M3, 0, 9);
        setup(0, 0, 9, 32'h0A); run(9);
        rd(G_STS, 0, v); chk("R8", "match at top value", v, 32'h0E);

        // R9: clear on read, event during read kept
        setup(0, 0, 1, 32'h02); run(2);
        rd(G_STS, 0, v); chk("R9", "first read", v, 32'h01);
        rd(G_STS, 0, v); chk("R9", "second read cleared", v, 32'h0);
        run(1);
        @(negedge clk);
        tick_en = 1'b1; rd_en = 1'b1; addr = ra(G_STS, 0);
        #(CLK_P/4);
        chk("R9", "read racing event", rdata, 32'h0);
        @(negedge clk);
        tick_en = 1'b0; rd_en = 1'b0;
        rd(G_STS, 0, v); chk("R9", "event kept", v, 32'h01);
        run(2); wr(G_STS, 0, 0);
        rd(G_STS, 0, v); chk("R9", "write does not clear", v, 32'h01);

        // R10: interrupt line
        setup(1, 0, 1, 32'h02); wr(G_IEN, 1, 0); run(2);
        #(CLK_P/4); chk("R10", "pending, not enabled", 32'(irq), 32'h0);
        wr(G_IEN, 1, 32'h10); #(CLK_P/4); chk("R10", "other bit enabled", 32'(irq), 32'h0);
        wr(G_IEN, 1, 32'h01); #(CLK_P/4); chk("R10", "enabled pending", 32'(irq), 32'h2);
        rd(G_STS, 1, v); #(CLK_P/4); chk("R10", "cleared by read", 32'(irq), 32'h0);
        wr(G_IEN, 1, 0);

        // R11: independence
        setup(0, 0, 0, 32'h01);
        setup(2, 0, 0, 32'h00);
        run(20);
        rd(G_CNT, 0, v); chk("R11", "stopped channel", v, 32'h0);
        rd(G_CNT, 2, v); chk("R11", "running channel", v, 32'd20);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule